// File: doc/BRIEF.md
# Infrared Run-Length Pulse Sampler

This block watches a serial infrared receive line and describes it as a sequence of runs. A run is a stretch of time in which the line holds one level. Once every T-period the block samples the line. The T-period is a programmable number of clock cycles. Each finished run becomes one code byte. The top bit of the byte gives the sampled bit value. The low seven bits give the run length in T-periods, minus one. Code bytes are queued in a small receive FIFO. A consumer drains the FIFO over a valid/ready stream.

Two registers control and report on the block. The configuration register holds a two-bit mode field and a receive-invert bit. The status register reports three flags: data ready, overrun and timeout. Reading the status register is signalled by a one-cycle strobe, and that strobe clears the overrun and timeout flags. Only the T-period sampling mode is active. The other three mode values park the sampler, and it produces no bytes while parked.

The output stream follows these back-pressure rules. `code_valid` is high whenever the FIFO holds a byte, and `code_data` is then the oldest byte. A byte leaves the FIFO on each rising edge where `code_valid` and `code_ready` are both high. While `code_ready` is low, `code_valid` and `code_data` stay unchanged unless a byte is taken.

Top module: `irrl_sampler`

## Requirements
- R1: After reset, `cfg_rdata` and `stat_rdata` both read 0x00 and `code_valid` is low.
- R2: Bit 7 of a code byte is the sampled bit value. Bits 6..0 are the run length in T-periods minus one, so a one-period run gives 0 and a 128-period run gives 0x7F.
- R3: With the invert bit (configuration bit 0) clear, a high input (IR energy) samples as bit value 0 and a low input samples as 1. With the invert bit set, both meanings are reversed.
- R4: A run ends and its byte is queued when a sample differs from the run's level. A run is also closed as soon as it reaches 128 T-periods, and the next sample then opens a fresh run.
- R5: Configuration bits 7..6 form the mode field. Only mode 00 samples the line. Modes 01, 10 and 11 clear any open run and queue no bytes. `cfg_rdata` reads back {mode, 5'b00000, invert}.
- R6: The FIFO holds 16 bytes and releases them in arrival order over valid/ready. While the FIFO is stalled, `code_valid` stays high and `code_data` holds its value.
- R7: A byte that arrives while the FIFO is full is dropped, the stored bytes are kept, and status bit 1 (overrun) is set.
- R8: Status bit 0 (data ready) is 1 exactly while the FIFO holds at least one byte.
- R9: Status bit 2 (timeout) is set when the FIFO is not empty and 512 T-periods (4 × 128) pass with no byte accepted into the FIFO and none taken from it.
- R10: A pulse on `stat_rd` clears status bits 1 and 2. If a new overrun or timeout event occurs in the same cycle, that event wins and its bit stays set.
- R11: The T-period lasts `tper_div` clock cycles, with 0 treated as 1. The line passes through a two-flip-flop synchroniser before it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_rx | input | 1 | Asynchronous infrared receive line, high = energy |
| tper_div | input | DIV_W | T-period length in clock cycles |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| stat_rd | input | 1 | Status read strobe; clears overrun and timeout |
| stat_rdata | output | 8 | Status: bit 2 timeout, bit 1 overrun, bit 0 data ready |
| code_valid | output | 1 | FIFO holds a code byte |
| code_ready | input | 1 | Consumer takes the byte at the next edge |
| code_data | output | 8 | Oldest code byte |

## Verification
The assertions assume that `code_ready`, `stat_rd` and `cfg_wr` are known, whole-cycle levels after reset. They also assume that the mode field changes only through `cfg_wr`. The idle property also relies on a byte leaving the run builder at most one cycle after the mode leaves 00. The stimulus changes every input on the falling clock edge. It holds each line level for a whole number of T-periods, with `tper_div` at least 3, so every level is sampled a known number of times despite the synchroniser delay. It keeps `code_ready` constant while bytes are being collected.

// File: rtl/irrl_pkg.sv
package irrl_pkg;
  localparam int CODE_W  = 8;
  localparam int LEN_W   = CODE_W - 1;
  localparam int RUN_MAX = 1 << LEN_W;

  typedef enum logic [1:0] {
    MODE_TPERIOD    = 2'b00,
    MODE_OVS        = 2'b01,
    MODE_OVS_RESYNC = 2'b10,
    MODE_FIFO_TEST  = 2'b11
  } irrl_mode_e;
endpackage

// File: rtl/irrl_tick.sv
module irrl_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) cnt <= '0;
    else                       cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/irrl_runlen.sv
module irrl_runlen
  import irrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rx_in,
  input  logic              invert,
  output logic              emit_v,
  output logic [CODE_W-1:0] emit_byte
);
  localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(RUN_MAX - 2);
  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(RUN_MAX - 1);

  logic             sync_a, sync_b;
  logic             samp_bit;
  logic             have_run, cur_bit;
  logic [LEN_W-1:0] run_len;

  // energy (high) reads as 0 unless inverted
  assign samp_bit = ~sync_b ^ invert;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= rx_in;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_run  <= 1'b0;
      cur_bit   <= 1'b0;
      run_len   <= '0;
      emit_v    <= 1'b0;
      emit_byte <= '0;
    end else begin
      emit_v <= 1'b0;
      if (!en) begin
        have_run <= 1'b0;
      end else if (tick) begin
        if (!have_run) begin
          have_run <= 1'b1;
          cur_bit  <= samp_bit;
          run_len  <= '0;
        end else if (samp_bit != cur_bit) begin
          emit_v    <= 1'b1;
          emit_byte <= {cur_bit, run_len};
          cur_bit   <= samp_bit;
          run_len   <= '0;
        end else if (run_len == LEN_LAST) begin
          emit_v    <= 1'b1;
          emit_byte <= {cur_bit, LEN_FULL};
          have_run  <= 1'b0;
        end else begin
          run_len <= run_len + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/irrl_fifo.sv
module irrl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + (AW+1)'(1);
      if (pop && !empty) rp <= rp + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/irrl_sampler.sv
module irrl_sampler
  import irrl_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int TO_RUNS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_rx,
  input  logic [DIV_W-1:0]  tper_div,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              stat_rd,
  output logic [7:0]        stat_rdata,
  output logic              code_valid,
  input  logic              code_ready,
  output logic [CODE_W-1:0] code_data
);
  localparam int TO_TICKS = TO_RUNS * RUN_MAX;
  localparam int TO_W     = $clog2(TO_TICKS + 1);

  irrl_mode_e        cfg_mode;
  logic              cfg_inv;
  logic              samp_en, tick;
  logic              emit_v;
  logic [CODE_W-1:0] emit_byte;
  logic              fifo_full, fifo_empty;
  logic              push_ok, pop_ok, ov_set, to_set;
  logic              ov_flag, to_flag;
  logic [TO_W-1:0]   to_cnt;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^cfg_wdata[5:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= MODE_TPERIOD;
      cfg_inv  <= 1'b0;
    end else if (cfg_wr) begin
      cfg_mode <= irrl_mode_e'(cfg_wdata[7:6]);
      cfg_inv  <= cfg_wdata[0];
    end
  end

  assign samp_en = (cfg_mode == MODE_TPERIOD);

  irrl_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(samp_en), .div(tper_div), .tick(tick)
  );

  irrl_runlen u_run (
    .clk(clk), .rst_n(rst_n), .en(samp_en), .tick(tick), .rx_in(ir_rx),
    .invert(cfg_inv), .emit_v(emit_v), .emit_byte(emit_byte)
  );

  irrl_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(emit_v), .din(emit_byte),
    .pop(code_ready), .dout(code_data), .full(fifo_full), .empty(fifo_empty)
  );

  assign code_valid = ~fifo_empty;
  assign push_ok    = emit_v && !fifo_full;
  assign pop_ok     = code_valid && code_ready;
  assign ov_set     = emit_v && fifo_full;
  assign to_set     = !fifo_empty && !push_ok && !pop_ok && tick &&
                      (to_cnt == TO_W'(TO_TICKS - 1));

  // idle-time counter in T-periods
  always_ff @(posedge clk) begin
    if (!rst_n || fifo_empty || push_ok || pop_ok) to_cnt <= '0;
    else if (to_set)                               to_cnt <= '0;
    else if (tick)                                 to_cnt <= to_cnt + TO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_flag <= 1'b0;
      to_flag <= 1'b0;
    end else begin
      ov_flag <= (ov_flag && !stat_rd) || ov_set;
      to_flag <= (to_flag && !stat_rd) || to_set;
    end
  end

  assign stat_rdata = {5'b00000, to_flag, ov_flag, code_valid};
  assign cfg_rdata  = {cfg_mode, 5'b00000, cfg_inv};
endmodule

// File: rtl/irrl_sampler_chk.sv
module irrl_sampler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       code_valid,
  input logic       code_ready,
  input logic [7:0] code_data,
  input logic       stat_rd,
  input logic [7:0] stat_rdata,
  input logic [1:0] mode,
  input logic       emit_v,
  input logic       fifo_full
);
  // R6: a stalled byte stays put
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready) |=> (code_valid && $stable(code_data)));

  // R7: overrun only rises after a byte met a full FIFO
  a_r7_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[1]) |-> $past(emit_v && fifo_full));

  // R9: timeout only rises while data was waiting
  a_r9_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[2]) |-> $past(code_valid));

  // R10: a read without a fresh overrun clears the flag
  a_r10_read_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(emit_v && fifo_full)) |=> !stat_rdata[1]);

  // R5: a parked sampler queues nothing
  a_r5_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && $past(mode) != 2'b00) |-> !emit_v);
endmodule

bind irrl_sampler irrl_sampler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_ready(code_ready),
  .code_data(code_data), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
  .mode(cfg_mode), .emit_v(emit_v), .fifo_full(fifo_full)
);

// File: tb/irrl_sampler_tb.sv
module irrl_sampler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_rx = 1'b0;
  logic [15:0] tper_div = 16'd5;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        stat_rd = 1'b0;
  logic [7:0]  stat_rdata;
  logic        code_valid;
  logic        code_ready = 1'b0;
  logic [7:0]  code_data;

  int checks = 0;
  int errors = 0;
  logic       collect = 1'b0;
  logic [7:0] got [64];
  int         ngot = 0;
  logic [7:0] exp_b [64];
  int         nexp;

  always #5 clk = ~clk;

  irrl_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .ir_rx(ir_rx), .tper_div(tper_div),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .code_valid(code_valid),
    .code_ready(code_ready), .code_data(code_data)
  );

  typedef struct packed {
    logic [3:0] div;
    logic       inv;
    logic       lvl;
    logic [8:0] na;
    logic [8:0] nb;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 1'b0, 1'b1, 9'd3,   9'd5},
    '{4'd5, 1'b1, 1'b1, 9'd3,   9'd5},
    '{4'd3, 1'b0, 1'b0, 9'd1,   9'd1},
    '{4'd5, 1'b0, 1'b1, 9'd128, 9'd2},
    '{4'd8, 1'b0, 1'b0, 9'd200, 9'd1},
    '{4'd5, 1'b1, 1'b0, 9'd129, 9'd127}
  };

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected bytes of one run, per R2/R3/R4
  task automatic add_run(input logic b, input int n);
    int left = n;
    while (left >= 128) begin
      exp_b[nexp] = {b, 7'h7F}; nexp++; left -= 128;
    end
    if (left > 0) begin
      exp_b[nexp] = {b, 7'(left - 1)}; nexp++;
    end
  endtask

  always @(negedge clk) begin
    if (collect && code_valid && code_ready && ngot < 64) begin
      got[ngot] = code_data;
      ngot++;
    end
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    chk("R1 cfg", int'(cfg_rdata), 8'h00);
    chk("R1 stat", int'(stat_rdata), 8'h00);
    chk("R1 valid", int'(code_valid), 0);

    // R5 read-back layout
    cfg_write(8'hFF);
    chk("R5 readback ff", int'(cfg_rdata), 8'hC1);
    cfg_write(8'h41);
    chk("R5 readback 41", int'(cfg_rdata), 8'h41);

    // R5 parked modes ignore line activity
    for (int m = 1; m < 4; m++) begin
      cfg_write({2'(m), 6'b0});
      for (int t = 0; t < 30; t++) begin
        ir_rx = ~ir_rx; wait_cyc(3);
      end
      wait_cyc(10);
      chk("R5 parked no bytes", int'(code_valid), 0);
    end

    // table of run patterns: R2 R3 R4 R6 R11
    code_ready = 1'b1;
    for (int v = 0; v < NV; v++) begin
      tper_div = 16'(VECS[v].div);
      cfg_write({2'b01, 5'b0, VECS[v].inv});
      ir_rx = VECS[v].lvl;
      wait_cyc(3);
      ngot = 0;
      collect = 1'b1;
      cfg_write({2'b00, 5'b0, VECS[v].inv});
      wait_cyc(int'(VECS[v].na) * int'(VECS[v].div));
      ir_rx = ~VECS[v].lvl;
      wait_cyc(int'(VECS[v].nb) * int'(VECS[v].div));
      ir_rx = VECS[v].lvl;
      wait_cyc(3 * int'(VECS[v].div));
      cfg_write({2'b01, 5'b0, VECS[v].inv});
      wait_cyc(10);
      collect = 1'b0;
      nexp = 0;
      add_run(~VECS[v].lvl ^ VECS[v].inv, int'(VECS[v].na));
      add_run(VECS[v].lvl ^ VECS[v].inv, int'(VECS[v].nb));
      chk("R4 byte count", ngot, nexp);
      for (int i = 0; i < nexp; i++)
        chk("R2 R3 R11 code byte", int'(got[i]), int'(exp_b[i]));
    end
    code_ready = 1'b0;
    wait_cyc(2);
    chk("R8 empty after drain", int'(stat_rdata), 8'h00);

    // overrun and timeout with a stalled consumer
    tper_div = 16'd5;
    ir_rx = 1'b1;
    cfg_write(8'h40);
    cfg_write(8'h00);
    wait_cyc(2 * 5);
    for (int t = 0; t < 20; t++) begin
      ir_rx = ~ir_rx; wait_cyc(5);
    end
    wait_cyc(5);
    chk("R7 overrun set", int'(stat_rdata), 8'h03);
    chk("R6 head held", int'(code_data), 8'h01);
    wait_cyc(400 * 5);
    chk("R9 no early timeout", int'(stat_rdata), 8'h03);
    chk("R6 head still held", int'(code_data), 8'h01);
    wait_cyc(200 * 5);
    chk("R9 timeout set", int'(stat_rdata), 8'h07);
    cfg_write(8'h40);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R10 read clears", int'(stat_rdata), 8'h01);

    // drain: oldest bytes kept, in order (R7, R6)
    ngot = 0;
    for (int i = 0; i < 20; i++) begin
      if (code_valid) begin
        got[ngot] = code_data; ngot++;
        code_ready = 1'b1;
        @(negedge clk);
        code_ready = 1'b0;
      end
    end
    chk("R6 R7 kept count", ngot, 16);
    chk("R7 first kept", int'(got[0]), 8'h01);
    chk("R6 order second", int'(got[1]), 8'h80);
    chk("R6 order last", int'(got[15]), 8'h80);
    chk("R8 ready clears", int'(stat_rdata), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule